// File: doc/BRIEF.md
# Board System Control Register File

This block is a word-addressed bank of board control registers on a minimal register bus. The bus has a word address, a write strobe, write data and a combinational read data return. It holds two oscillator setting words and a free-form init word. The two oscillator words can only be changed after a 16-bit key has been written to a lock register. It also holds a control word, two pairs of set/clear flag words, a free-running reference counter and a small interrupt group. That group has an enable mask and a software-triggered level.

Software uses the control word to choose what appears at address zero, to drive a board LED and to request a system reset. The reset request is not stored. It leaves the block as a single-cycle pulse. The reference counter advances on a clock-enable tick, which the surrounding logic generates at the fixed reference rate. A read of the counter returns the number of ticks seen since reset.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the following reads hold: word 0 (identity) reads 0x411A3001, word 4 (status) 0x00100000, word 2 (oscillator) 0x01000048, word 7 (auxiliary oscillator) 0x0007FEFF and word 9 (init) 0x00000112. The lock, control, flag, counter and interrupt words read zero, and all three outputs are low.
- R2: A write to word 5 (lock) stores only data bits 15:0. Writes to word 2 and word 7 change those registers only while the stored lock value is 0xA05F. Otherwise they are dropped.
- R3: A read of word 5 returns 0x0001A05F while the stored lock value is 0xA05F, where bit 16 marks the unlocked state. Otherwise it returns the stored 16-bit value with the upper bits zero.
- R4: A write to word 3 (control) with data bit 3 set drives `sys_rst_req` high for exactly the one cycle after the write edge. Control bit 3 always reads zero.
- R5: A control write replaces control bits 0 and 2 with the written bits and ignores all other data bits. Bit 0 drives `led_on`. Bit 2 drives `remap_ram`, where 1 means RAM at address zero and 0 means boot flash.
- R6: A write to word 12 ORs the data into the flags word, and a write to word 13 clears the flags bits that are 1 in the data. Words 14 and 15 act the same way on the non-volatile flags word. Words 12 and 14 read the respective words.
- R7: Word 10 reads a 32-bit count that starts at zero at reset and increases by one at each clock edge where `ref_tick` is high.
- R8: A write to word 18 ORs the data into the interrupt enable mask, and a write to word 19 clears the mask bits that are 1 in the data. Word 18 reads the mask.
- R9: The software interrupt level is bit 0 alone. A write to word 20 sets it if data bit 0 is 1, and a write to word 21 clears it if data bit 0 is 1. Words 20 and 17 read the level. Word 16 reads the level ANDed with the enable mask.
- R10: Writes to unmapped words or to read-only words change nothing, and reads of unmapped words return zero. Words 32 to 35 (voltage) behave as unmapped.
- R11: Word 9 holds any 32-bit value written to it and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference-rate clock enable for the counter |
| bus_addr | input | 6 | Word address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| led_on | output | 1 | LED state, control bit 0 |
| remap_ram | output | 1 | Address-zero select, control bit 2 |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case is a locked oscillator write that arrives after the lock has been opened and then closed again. If such a write leaks through, the only trace is an oscillator value that should not have changed. The stimulus therefore moves the lock through reset, a wrong key, the correct key written with junk in the upper half, and back to a wrong key. It writes an oscillator value at each step and reads back both the lock and the oscillator after every step. The reset pulse is checked in the cycle after its write and again in the cycle after that, so a pulse that is stored or too long is caught.

// File: rtl/sysctl_pkg.sv
// Package: shared word offsets, reset constants and the unlock key for the
// system control register file. Assumes a word-addressed bus.
package sysctl_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F;
    localparam logic [DATA_W-1:0] ID_VAL      = 32'h411A3001;
    localparam logic [DATA_W-1:0] STAT_VAL    = 32'h00100000;
    localparam logic [DATA_W-1:0] OSC_RST     = 32'h01000048;
    localparam logic [DATA_W-1:0] AUX_RST     = 32'h0007FEFF;
    localparam logic [DATA_W-1:0] INIT_RST    = 32'h00000112;

    localparam logic [ADDR_W-1:0] W_ID       = 6'd0;
    localparam logic [ADDR_W-1:0] W_OSC      = 6'd2;
    localparam logic [ADDR_W-1:0] W_CTRL     = 6'd3;
    localparam logic [ADDR_W-1:0] W_STAT     = 6'd4;
    localparam logic [ADDR_W-1:0] W_LOCK     = 6'd5;
    localparam logic [ADDR_W-1:0] W_AUX      = 6'd7;
    localparam logic [ADDR_W-1:0] W_INIT     = 6'd9;
    localparam logic [ADDR_W-1:0] W_REFCNT   = 6'd10;
    localparam logic [ADDR_W-1:0] W_FLG_SET  = 6'd12;
    localparam logic [ADDR_W-1:0] W_FLG_CLR  = 6'd13;
    localparam logic [ADDR_W-1:0] W_NVF_SET  = 6'd14;
    localparam logic [ADDR_W-1:0] W_NVF_CLR  = 6'd15;
    localparam logic [ADDR_W-1:0] W_INT_MASK = 6'd16;
    localparam logic [ADDR_W-1:0] W_INT_RAW  = 6'd17;
    localparam logic [ADDR_W-1:0] W_EN_SET   = 6'd18;
    localparam logic [ADDR_W-1:0] W_EN_CLR   = 6'd19;
    localparam logic [ADDR_W-1:0] W_SW_SET   = 6'd20;
    localparam logic [ADDR_W-1:0] W_SW_CLR   = 6'd21;

    // Control word bit positions
    localparam int CTL_LED   = 0;
    localparam int CTL_REMAP = 2;
    localparam int CTL_RESET = 3;
endpackage

// File: rtl/sysctl_keyed_osc.sv
// Keyed oscillator pair: a lock register plus two setting registers that
// accept writes only while the lock holds the unlock key.
// Assumes one-hot write enables decoded by the parent and DATA_W > KEY_W.
module sysctl_keyed_osc #(
    parameter int DATA_W = 32,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0]  KEY     = 16'hA05F,
    parameter logic [DATA_W-1:0] OSC_INI = '0,
    parameter logic [DATA_W-1:0] AUX_INI = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic              wr_osc,
    input  logic              wr_aux,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lock_rd,
    output logic [DATA_W-1:0] osc_q,
    output logic [DATA_W-1:0] aux_q
);
    localparam int PAD_W = DATA_W - KEY_W - 1;

    logic [KEY_W-1:0] lock_q;
    logic             open_w;

    // Key comparison, shared by the write gate and the read view
    assign open_w = (lock_q == KEY);

    // Lock register keeps the low key-width bits of each write
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '0;
        else if (wr_lock) lock_q <= wdata[KEY_W-1:0];
    end

    // Oscillator settings update only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q <= OSC_INI;
            aux_q <= AUX_INI;
        end else begin
            if (wr_osc && open_w) osc_q <= wdata;
            if (wr_aux && open_w) aux_q <= wdata;
        end
    end

    // Read view: flag bit above the key marks the unlocked state
    assign lock_rd = {{PAD_W{1'b0}}, open_w, lock_q};

    p_locked_osc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_osc && (lock_q != KEY)) |-> osc_q == $past(osc_q));
    p_locked_aux_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_aux && (lock_q != KEY)) |-> aux_q == $past(aux_q));
    p_lock_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_lock) |-> lock_q == $past(wdata[KEY_W-1:0]));
endmodule

// File: rtl/sysctl_ctrl.sv
// Control word: holds the LED and remap bits and turns the reset bit of a
// write into a registered one-cycle request. Assumes a decoded write enable.
module sysctl_ctrl #(
    parameter int DATA_W  = 32,
    parameter int LED_B   = 0,
    parameter int REMAP_B = 2,
    parameter int RST_B   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic              led_on,
    output logic              remap_ram,
    output logic              rst_req
);
    // Stored bits: only LED and remap are kept from a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_on    <= 1'b0;
            remap_ram <= 1'b0;
        end else if (wr_ctrl) begin
            led_on    <= wdata[LED_B];
            remap_ram <= wdata[REMAP_B];
        end
    end

    // Reset request pulse, registered from the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= wr_ctrl && wdata[RST_B];
    end

    // Read view: reset bit never appears
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[LED_B]   = led_on;
        ctrl_rd[REMAP_B] = remap_ram;
    end

    p_rst_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wr_ctrl && wdata[RST_B]));
    p_rst_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_ctrl && wdata[RST_B]) |-> rst_req);
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !wr_ctrl) |-> ($stable(led_on) && $stable(remap_ram)));
endmodule

// File: rtl/sysctl_setclr.sv
// Generic set/clear register: a set write ORs data in, a clear write removes
// the data's one bits. Assumes set and clear are never asserted together.
module sysctl_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Bitwise set and clear update
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end

    p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && set_we) |-> (q & $past(wdata)) == $past(wdata));
    p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && clr_we && !set_we) |-> (q & $past(wdata)) == '0);
endmodule

// File: rtl/sysctl_refcnt.sv
// Reference counter: counts clock-enable ticks from zero at reset and wraps
// at its width. Assumes the tick is synchronous to clk.
module sysctl_refcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    // Advance once per tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && tick) |-> cnt == $past(cnt) + 1'b1);
    p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !tick) |-> $stable(cnt));
endmodule

// File: rtl/sysctl_regfile.sv
// System control register file top: decodes word writes, instantiates the
// keyed oscillators, control word, set/clear banks, interrupt group and
// reference counter, and muxes reads. Assumes reads are combinational from
// bus_addr and at most one write per cycle.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          led_on,
    output logic          remap_ram,
    output logic          sys_rst_req
);
    localparam int NBANK = 2;

    logic [DW-1:0] lock_rd, osc_q, aux_q, ctrl_rd, init_q, cnt_q, en_q;
    logic [DW-1:0] bank_q [NBANK];
    logic          sw_lvl;
    logic          sw_set, sw_clr;

    // Per-bank set and clear addresses: bank 0 flags, bank 1 non-volatile
    function automatic logic [AW-1:0] bank_set_addr(input int b);
        return (b == 0) ? W_FLG_SET : W_NVF_SET;
    endfunction
    function automatic logic [AW-1:0] bank_clr_addr(input int b);
        return (b == 0) ? W_FLG_CLR : W_NVF_CLR;
    endfunction

    // Write hit for a given word
    function automatic logic hit(input logic [AW-1:0] a);
        return bus_wr && (bus_addr == a);
    endfunction

    sysctl_keyed_osc #(
        .DATA_W(DW), .KEY_W(KEY_W), .KEY(UNLOCK_KEY),
        .OSC_INI(OSC_RST), .AUX_INI(AUX_RST)
    ) osc_i (
        .clk(clk), .rst_n(rst_n),
        .wr_lock(hit(W_LOCK)), .wr_osc(hit(W_OSC)), .wr_aux(hit(W_AUX)),
        .wdata(bus_wdata),
        .lock_rd(lock_rd), .osc_q(osc_q), .aux_q(aux_q)
    );

    sysctl_ctrl #(
        .DATA_W(DW), .LED_B(CTL_LED), .REMAP_B(CTL_REMAP), .RST_B(CTL_RESET)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(hit(W_CTRL)), .wdata(bus_wdata),
        .ctrl_rd(ctrl_rd), .led_on(led_on), .remap_ram(remap_ram),
        .rst_req(sys_rst_req)
    );

    // Flag banks share one set/clear structure
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sysctl_setclr #(.W(DW)) bank_i (
            .clk(clk), .rst_n(rst_n),
            .set_we(hit(bank_set_addr(b))), .clr_we(hit(bank_clr_addr(b))),
            .wdata(bus_wdata), .q(bank_q[b])
        );
    end

    // Interrupt enable mask reuses the set/clear structure
    sysctl_setclr #(.W(DW)) en_i (
        .clk(clk), .rst_n(rst_n),
        .set_we(hit(W_EN_SET)), .clr_we(hit(W_EN_CLR)),
        .wdata(bus_wdata), .q(en_q)
    );

    // Software level: acts only when data bit 0 is one
    assign sw_set = hit(W_SW_SET) && bus_wdata[0];
    assign sw_clr = hit(W_SW_CLR) && bus_wdata[0];

    sysctl_setclr #(.W(1)) sw_i (
        .clk(clk), .rst_n(rst_n),
        .set_we(sw_set), .clr_we(sw_clr),
        .wdata(1'b1), .q(sw_lvl)
    );

    sysctl_refcnt #(.W(DW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .cnt(cnt_q)
    );

    // Plain init register
    always_ff @(posedge clk) begin
        if (!rst_n)            init_q <= INIT_RST;
        else if (hit(W_INIT))  init_q <= bus_wdata;
    end

    // Read multiplexer; unmapped and voltage words fall to zero
    always_comb begin
        unique case (bus_addr)
            W_ID:       bus_rdata = ID_VAL;
            W_OSC:      bus_rdata = osc_q;
            W_CTRL:     bus_rdata = ctrl_rd;
            W_STAT:     bus_rdata = STAT_VAL;
            W_LOCK:     bus_rdata = lock_rd;
            W_AUX:      bus_rdata = aux_q;
            W_INIT:     bus_rdata = init_q;
            W_REFCNT:   bus_rdata = cnt_q;
            W_FLG_SET:  bus_rdata = bank_q[0];
            W_NVF_SET:  bus_rdata = bank_q[1];
            W_INT_MASK: bus_rdata = {{(DW-1){1'b0}}, sw_lvl & en_q[0]};
            W_INT_RAW:  bus_rdata = {{(DW-1){1'b0}}, sw_lvl};
            W_EN_SET:   bus_rdata = en_q;
            W_SW_SET:   bus_rdata = {{(DW-1){1'b0}}, sw_lvl};
            default:    bus_rdata = '0;
        endcase
    end

    p_sw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_set) |-> sw_lvl);
    p_sw_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_clr) |-> !sw_lvl);
    p_init_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_wr && bus_addr == W_INIT) |-> init_q == $past(bus_wdata));
endmodule

// File: tb/sysctl_regfile_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor at the
// falling edge pops and compares them against the design's ports.
module sysctl_regfile_tb_top;
    localparam int KIND_RD  = 0;
    localparam int KIND_RST = 1;
    localparam int KIND_LED = 2;
    localparam int KIND_MAP = 3;

    typedef struct {
        int          kind;
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        led_on, remap_ram, sys_rst_req;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    ticks = 0;

    always #5 clk = ~clk;

    sysctl_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .led_on(led_on), .remap_ram(remap_ram),
        .sys_rst_req(sys_rst_req)
    );

    // Monitor: compare every pending item at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    KIND_RD:  act = bus_rdata;
                    KIND_RST: act = {31'd0, sys_rst_req};
                    KIND_LED: act = {31'd0, led_on};
                    default:  act = {31'd0, remap_ram};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    // Tasks start and end 1 ns after a rising edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = KIND_RD; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic expect_pin(input int k, input logic e, input string tag);
        item_t it;
        it.kind = k; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic run_ticks(input int n);
        ref_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
        ref_tick = 1'b0;
        ticks += n;
    endtask

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        expect_pin(KIND_LED, 1'b0, "R1 led");
        expect_pin(KIND_MAP, 1'b0, "R1 remap");
        expect_pin(KIND_RST, 1'b0, "R1 rst_req");
        expect_rd(6'd0,  32'h411A3001, "R1 id");
        expect_rd(6'd4,  32'h00100000, "R1 stat");
        expect_rd(6'd2,  32'h01000048, "R1 osc");
        expect_rd(6'd7,  32'h0007FEFF, "R1 aux");
        expect_rd(6'd9,  32'h00000112, "R1 init");
        expect_rd(6'd5,  32'h0,        "R1 lock");
        expect_rd(6'd3,  32'h0,        "R1 ctrl");
        expect_rd(6'd10, 32'h0,        "R1 refcnt");
        expect_rd(6'd12, 32'h0,        "R1 flags");

        // R2 locked writes dropped, key opens, low 16 bits only
        wr(6'd2, 32'h00001234);
        expect_rd(6'd2, 32'h01000048, "R2 osc locked");
        wr(6'd5, 32'h0000A05E);
        wr(6'd7, 32'h00000077);
        expect_rd(6'd7, 32'h0007FEFF, "R2 aux wrong key");
        expect_rd(6'd5, 32'h0000A05E, "R3 lock wrong key");
        wr(6'd5, 32'h1234A05F);
        expect_rd(6'd5, 32'h0001A05F, "R3 lock unlocked view");
        wr(6'd2, 32'hCAFE0001);
        expect_rd(6'd2, 32'hCAFE0001, "R2 osc unlocked");
        wr(6'd7, 32'h00000055);
        expect_rd(6'd7, 32'h00000055, "R2 aux unlocked");
        wr(6'd5, 32'h0000BEEF);
        expect_rd(6'd5, 32'h0000BEEF, "R3 lock relocked");
        wr(6'd2, 32'h00000009);
        expect_rd(6'd2, 32'hCAFE0001, "R2 osc relocked");

        // R4 R5 control word
        wr(6'd3, 32'hFFFFFFFF);
        expect_pin(KIND_RST, 1'b1, "R4 pulse high");
        expect_pin(KIND_LED, 1'b1, "R5 led set");
        expect_pin(KIND_MAP, 1'b1, "R5 remap set");
        expect_rd(6'd3, 32'h00000005, "R4 R5 ctrl readback");
        expect_pin(KIND_RST, 1'b0, "R4 pulse one cycle");
        wr(6'd3, 32'h00000004);
        expect_pin(KIND_RST, 1'b0, "R4 no pulse");
        expect_pin(KIND_LED, 1'b0, "R5 led clear");
        expect_pin(KIND_MAP, 1'b1, "R5 remap kept");
        expect_rd(6'd3, 32'h00000004, "R5 ctrl remap only");
        wr(6'd3, 32'h00000008);
        expect_pin(KIND_RST, 1'b1, "R4 reset-only pulse");
        expect_pin(KIND_MAP, 1'b0, "R5 remap to flash");
        expect_rd(6'd3, 32'h00000000, "R4 bit3 reads zero");
        expect_pin(KIND_RST, 1'b0, "R4 pulse ends");
        expect_rd(6'd3, 32'h00000000, "R4 idle");

        // R6 flag banks
        wr(6'd12, 32'h000000F0);
        wr(6'd12, 32'h0000000F);
        expect_rd(6'd12, 32'h000000FF, "R6 flags set");
        wr(6'd13, 32'h0000003C);
        expect_rd(6'd12, 32'h000000C3, "R6 flags clear");
        wr(6'd14, 32'hA5000000);
        wr(6'd15, 32'h05000000);
        expect_rd(6'd14, 32'hA0000000, "R6 nvflags");
        expect_rd(6'd12, 32'h000000C3, "R6 flags independent");

        // R7 reference counter
        run_ticks(37);
        expect_rd(6'd10, ticks, "R7 count after ticks");
        expect_rd(6'd10, ticks, "R7 holds without tick");
        run_ticks(5);
        expect_rd(6'd10, ticks, "R7 count continues");

        // R8 enable mask
        wr(6'd18, 32'h00000003);
        expect_rd(6'd18, 32'h00000003, "R8 enable set");
        wr(6'd19, 32'h00000001);
        expect_rd(6'd18, 32'h00000002, "R8 enable clear");

        // R9 software level
        expect_rd(6'd20, 32'h0, "R9 soft idle");
        wr(6'd20, 32'h00000002);
        expect_rd(6'd20, 32'h0, "R9 bit0 only");
        wr(6'd20, 32'h00000001);
        expect_rd(6'd20, 32'h1, "R9 soft set");
        expect_rd(6'd17, 32'h1, "R9 raw");
        expect_rd(6'd16, 32'h0, "R9 masked off");
        wr(6'd18, 32'h00000001);
        expect_rd(6'd16, 32'h1, "R9 masked on");
        wr(6'd21, 32'h00000000);
        expect_rd(6'd20, 32'h1, "R9 clear needs bit0");
        wr(6'd21, 32'h00000001);
        expect_rd(6'd20, 32'h0, "R9 soft clear");
        expect_rd(6'd16, 32'h0, "R9 masked cleared");

        // R10 unmapped and read-only words
        wr(6'd33, 32'hFFFFFFFF);
        expect_rd(6'd33, 32'h0, "R10 voltage zero");
        wr(6'd40, 32'hFFFFFFFF);
        expect_rd(6'd40, 32'h0, "R10 unmapped zero");
        wr(6'd0, 32'h0);
        expect_rd(6'd0, 32'h411A3001, "R10 id read-only");
        wr(6'd4, 32'h0);
        expect_rd(6'd4, 32'h00100000, "R10 stat read-only");
        expect_rd(6'd12, 32'h000000C3, "R10 flags untouched");
        expect_rd(6'd2, 32'hCAFE0001, "R10 osc untouched");

        // R11 init register
        wr(6'd9, 32'hABCD1234);
        expect_rd(6'd9, 32'hABCD1234, "R11 init write");

        @(posedge clk); #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule